// File: doc/BRIEF.md
# High-Speed Entry Settle and Sync Detector

This block sits on one lane of a camera serial receiver. It watches two views of the lane: the decoded low-power line pair and the byte stream from the high-speed deserializer. From these it decides when a high-speed burst has really started. Once it sees the entry request on the low-power pair, it counts cycles of the byte clock. A termination-enable output rises after a programmed number of cycles. The byte stream is held masked until a second programmed count has run out. After that the block looks for the sync byte at any of the eight bit offsets. When it finds it, it locks that offset, marks the lane aligned, pulses start-of-burst and from then on emits realigned bytes.

Everything is driven by a small state machine with these states:
- `ST_IDLE`: no valid stop state seen.
- `ST_STOP`: LP-11 seen.
- `ST_HSREQ`: LP-01 seen after stop.
- `ST_SETTLE`: counting after LP-00, data masked.
- `ST_HUNT`: sync search.
- `ST_LOCKED`: aligned.
- `ST_FAIL`: search exhausted.
- `ST_CLKHS`: clock-lane mode, settled, no search.

The transitions are:
- Any state goes to `ST_STOP` on LP-11.
- IDLE stays in IDLE until LP-11 is seen.
- STOP goes to HSREQ on LP-01 and to IDLE on any other code.
- HSREQ goes to SETTLE on LP-00, stays on LP-01, and goes to IDLE on LP-10.
- SETTLE goes to HUNT, or to CLKHS in clock mode, once the settle count is reached.
- HUNT goes to LOCKED on a match, or to FAIL after the last allowed window.
- LOCKED, FAIL and CLKHS are held until stop.

The same block serves a clock lane when clock mode is selected. In that mode it uses the clock-lane term and settle counts. A disable flag replaces those programmed clock-lane counts with built-in values of 0 and 14. The intended programming is:
- data-lane term count: floor(20 ns / clock period)
- data-lane settle count: floor(105 ns / clock period) + 4
- sync pattern: 0xB8

Top module: `dphy_hs_entry`

## Requirements
- R1: After reset every output is low and the state machine waits for LP-11 before any burst can begin.
- R2: The low-power pair is coded `lp_state[1]` = positive line, `lp_state[0]` = negative line. A burst starts only after 2'b11, then 2'b01 (which may be held for several cycles), then 2'b00. The sequence 2'b11 followed directly by 2'b00 starts nothing.
- R3: Counting is defined as follows:
  - Cycle 0 is the cycle after the one in which 2'b00 first completes the entry sequence.
  - `term_en` is high from cycle `cfg_term_cnt` onward.
  - `term_en` stays high until LP-11 is seen.
- R4: Bytes presented before cycle `cfg_settle_cnt` are never examined for sync. The byte of cycle `cfg_settle_cnt` is the first eligible one.
- R5: Each search cycle forms a 16-bit window, with the current byte in bits 15:8 and the previous byte in bits 7:0; bit 0 is the earliest bit. Offset o tests window bits o+7..o against `cfg_sync_pat`, for o in 0..7. When several offsets match, the lowest one wins.
- R6: In the cycle after the matching window, `aligned` rises and `sob_pulse` is high for exactly that cycle. While aligned, `out_byte` is bits o+7..o of the current window.
- R7: LP-11 in any cycle sends the state machine to stop. From the next cycle `aligned`, `term_en`, `clk_active` and `sync_err` are low, and the counters restart at the next entry.
- R8: While `aligned` is low, `out_byte` is zero.
- R9: If none of `HUNT_LIMIT` search windows (default 16) matches, `sync_err` pulses for one cycle in the cycle after the last window. No lock follows until a new entry.
- R10: When `cfg_clock_mode` is high:
  - no sync search is made;
  - `term_en` follows `cfg_clk_term`;
  - `clk_active` rises in cycle `cfg_clk_settle`+1.
- R11: When `cfg_clock_mode` and `cfg_clkcfg_dis` are both high, the clock-lane counts are 0 (term) and 14 (settle), whatever `cfg_clk_term` and `cfg_clk_settle` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte/counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_state | input | 2 | Decoded low-power line pair {positive, negative} |
| hs_byte | input | 8 | Deserialized high-speed byte |
| cfg_term_cnt | input | 8 | Data-lane termination delay count |
| cfg_settle_cnt | input | 8 | Data-lane settle count |
| cfg_sync_pat | input | 8 | Sync byte pattern |
| cfg_clock_mode | input | 1 | Lane acts as clock lane |
| cfg_clk_term | input | 8 | Clock-lane termination count |
| cfg_clk_settle | input | 8 | Clock-lane settle count |
| cfg_clkcfg_dis | input | 1 | Use built-in clock-lane counts |
| term_en | output | 1 | Termination enable |
| aligned | output | 1 | Sync locked, output bytes valid |
| sob_pulse | output | 1 | Start-of-burst pulse |
| out_byte | output | 8 | Realigned byte, zero when not aligned |
| sync_err | output | 1 | Sync search exhausted pulse |
| clk_active | output | 1 | Clock lane settled in high-speed mode |

## Verification
The hardest case to reach from the ports is a sync byte that straddles two bytes at a non-zero offset while other offsets nearly match. Close behind it is a sync byte placed one cycle before settle expiry, which must be ignored.

The stimulus first walks the low-power sequence into a burst with known term and settle counts. It then places hand-built byte pairs at exact cycle indices counted from entry. One pair encodes the pattern shifted by three bits. An all-zero stream with a zero pattern makes every offset match at once, which exposes the priority order.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STOP,
        ST_HSREQ,
        ST_SETTLE,
        ST_HUNT,
        ST_LOCKED,
        ST_FAIL,
        ST_CLKHS
    } hsd_state_e;

    // low-power line pair codes {positive, negative}
    localparam logic [1:0] LP_STOP   = 2'b11;
    localparam logic [1:0] LP_REQ    = 2'b01;
    localparam logic [1:0] LP_BRIDGE = 2'b00;

endpackage

// File: rtl/hsd_timer.sv
module hsd_timer #(
    parameter int CNT_W      = 8,
    parameter int HUNT_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hunt_run,
    input  logic [CNT_W-1:0] term_lim,
    input  logic [CNT_W-1:0] settle_lim,
    output logic             term_hit,
    output logic             settle_hit,
    output logic             hunt_last
);

    localparam int HW = $clog2(HUNT_LIMIT) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [HW-1:0]    HUNT_END = HW'(HUNT_LIMIT - 1);

    logic [CNT_W-1:0] cyc_q;
    logic [HW-1:0]    hunt_q;

    // cycles since burst entry, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (!run) begin
            cyc_q <= '0;
        end else if (cyc_q != CNT_MAX) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // windows examined during the search
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hunt_q <= '0;
        end else if (!hunt_run) begin
            hunt_q <= '0;
        end else if (hunt_q != HUNT_END) begin
            hunt_q <= hunt_q + 1'b1;
        end
    end

    assign term_hit   = run && (cyc_q >= term_lim);
    assign settle_hit = run && (cyc_q >= settle_lim);
    assign hunt_last  = hunt_run && (hunt_q == HUNT_END);

endmodule

// File: rtl/hsd_sync_hunt.sv
module hsd_sync_hunt #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] hs_byte,
    input  logic [BYTE_W-1:0] pattern,
    input  logic              lock_ld,
    input  logic              locked,
    output logic              hit,
    output logic [BYTE_W-1:0] out_byte
);

    localparam int OFF_W = $clog2(BYTE_W);
    localparam int WIN_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] prev_q;
    logic [WIN_W-1:0]  window;
    logic [BYTE_W-1:0] hit_vec;
    logic [OFF_W-1:0]  hit_off;
    logic [OFF_W-1:0]  off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= hs_byte;
        end
    end

    // earliest bit sits in the previous byte's bit 0
    assign window = {hs_byte, prev_q};

    genvar o;
    generate
        for (o = 0; o < BYTE_W; o++) begin : g_off
            assign hit_vec[o] = (window[o +: BYTE_W] == pattern);
        end
    endgenerate

    // lowest matching offset takes priority
    always_comb begin
        hit_off = '0;
        for (int k = BYTE_W - 1; k >= 0; k--) begin
            if (hit_vec[k]) begin
                hit_off = OFF_W'(k);
            end
        end
    end

    assign hit = |hit_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (lock_ld) begin
            off_q <= hit_off;
        end
    end

    assign out_byte = locked ? window[off_q +: BYTE_W] : '0;

endmodule

// File: rtl/dphy_hs_entry.sv
module dphy_hs_entry #(
    parameter int CNT_W          = 8,
    parameter int BYTE_W         = 8,
    parameter int HUNT_LIMIT     = 16,
    parameter int CLK_TERM_DEF   = 0,
    parameter int CLK_SETTLE_DEF = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lp_state,
    input  logic [BYTE_W-1:0] hs_byte,
    input  logic [CNT_W-1:0]  cfg_term_cnt,
    input  logic [CNT_W-1:0]  cfg_settle_cnt,
    input  logic [BYTE_W-1:0] cfg_sync_pat,
    input  logic              cfg_clock_mode,
    input  logic [CNT_W-1:0]  cfg_clk_term,
    input  logic [CNT_W-1:0]  cfg_clk_settle,
    input  logic              cfg_clkcfg_dis,
    output logic              term_en,
    output logic              aligned,
    output logic              sob_pulse,
    output logic [BYTE_W-1:0] out_byte,
    output logic              sync_err,
    output logic              clk_active
);

    import hsd_pkg::*;

    localparam logic [CNT_W-1:0] CLK_TERM_D   = CNT_W'(CLK_TERM_DEF);
    localparam logic [CNT_W-1:0] CLK_SETTLE_D = CNT_W'(CLK_SETTLE_DEF);

    hsd_state_e state_q, state_nxt;
    logic       entered_q;
    logic       run, hunt_run, lock_ld;
    logic       term_hit, settle_hit, hunt_last, hit;
    logic [CNT_W-1:0] term_lim, settle_lim;

    // count selection: data lane, programmed clock lane, built-in clock lane
    always_comb begin
        if (!cfg_clock_mode) begin
            term_lim   = cfg_term_cnt;
            settle_lim = cfg_settle_cnt;
        end else if (cfg_clkcfg_dis) begin
            term_lim   = CLK_TERM_D;
            settle_lim = CLK_SETTLE_D;
        end else begin
            term_lim   = cfg_clk_term;
            settle_lim = cfg_clk_settle;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        if (lp_state == LP_STOP) begin
            state_nxt = ST_STOP;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_nxt = ST_IDLE;
                ST_STOP:   state_nxt = (lp_state == LP_REQ) ? ST_HSREQ : ST_IDLE;
                ST_HSREQ: begin
                    if (lp_state == LP_BRIDGE) begin
                        state_nxt = ST_SETTLE;
                    end else if (lp_state != LP_REQ) begin
                        state_nxt = ST_IDLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_hit) begin
                        state_nxt = cfg_clock_mode ? ST_CLKHS : ST_HUNT;
                    end
                end
                ST_HUNT: begin
                    if (hit) begin
                        state_nxt = ST_LOCKED;
                    end else if (hunt_last) begin
                        state_nxt = ST_FAIL;
                    end
                end
                ST_LOCKED: state_nxt = ST_LOCKED;
                ST_FAIL:   state_nxt = ST_FAIL;
                ST_CLKHS:  state_nxt = ST_CLKHS;
                default:   state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            entered_q <= 1'b0;
        end else begin
            state_q   <= state_nxt;
            entered_q <= (state_nxt != state_q);
        end
    end

    assign run      = (state_q == ST_SETTLE) || (state_q == ST_HUNT) ||
                      (state_q == ST_LOCKED) || (state_q == ST_FAIL) ||
                      (state_q == ST_CLKHS);
    assign hunt_run = (state_q == ST_HUNT);
    assign lock_ld  = (state_q == ST_HUNT) && (state_nxt == ST_LOCKED);

    hsd_timer #(
        .CNT_W      (CNT_W),
        .HUNT_LIMIT (HUNT_LIMIT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .hunt_run   (hunt_run),
        .term_lim   (term_lim),
        .settle_lim (settle_lim),
        .term_hit   (term_hit),
        .settle_hit (settle_hit),
        .hunt_last  (hunt_last)
    );

    hsd_sync_hunt #(
        .BYTE_W (BYTE_W)
    ) u_hunt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_byte  (hs_byte),
        .pattern  (cfg_sync_pat),
        .lock_ld  (lock_ld),
        .locked   (state_q == ST_LOCKED),
        .hit      (hit),
        .out_byte (out_byte)
    );

    // outputs
    always_comb begin
        term_en    = term_hit;
        aligned    = (state_q == ST_LOCKED);
        sob_pulse  = (state_q == ST_LOCKED) && entered_q;
        sync_err   = (state_q == ST_FAIL) && entered_q;
        clk_active = (state_q == ST_CLKHS);
    end

endmodule

// File: rtl/dphy_hs_entry_chk.sv
module dphy_hs_entry_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        lp_state,
    input logic              term_en,
    input logic              aligned,
    input logic              sob_pulse,
    input logic [BYTE_W-1:0] out_byte,
    input logic              sync_err,
    input logic              clk_active
);

    a_r3_term_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (term_en && lp_state != 2'b11) |=> term_en);

    a_r6_sob_single: assert property (@(posedge clk) disable iff (!rst_n)
        sob_pulse |=> !sob_pulse);

    a_r6_sob_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> sob_pulse);

    a_r6_sob_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        sob_pulse |-> aligned);

    a_r7_stop_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_state == 2'b11) |=> (!aligned && !term_en && !clk_active && !sync_err));

    a_r8_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |-> (out_byte == '0));

    a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> !sync_err);

    a_r10_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({aligned, clk_active, sync_err}));

endmodule

bind dphy_hs_entry dphy_hs_entry_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lp_state   (lp_state),
    .term_en    (term_en),
    .aligned    (aligned),
    .sob_pulse  (sob_pulse),
    .out_byte   (out_byte),
    .sync_err   (sync_err),
    .clk_active (clk_active)
);

// File: tb/sim_dphy_hs_entry.sv
`timescale 1ns/1ps
module sim_dphy_hs_entry;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lp = 2'b10;
    logic [7:0] hb = 8'h00;
    logic [7:0] c_term = 8'd0, c_settle = 8'd5, c_pat = 8'hB8;
    logic       c_cmode = 1'b0, c_cdis = 1'b0;
    logic [7:0] c_cterm = 8'd3, c_csettle = 8'd4;

    logic       term_en, aligned, sob_pulse, sync_err, clk_active;
    logic [7:0] out_byte;

    logic       o_term, o_al, o_sob, o_err, o_clk;
    logic [7:0] o_byte;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dphy_hs_entry u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .lp_state       (lp),
        .hs_byte        (hb),
        .cfg_term_cnt   (c_term),
        .cfg_settle_cnt (c_settle),
        .cfg_sync_pat   (c_pat),
        .cfg_clock_mode (c_cmode),
        .cfg_clk_term   (c_cterm),
        .cfg_clk_settle (c_csettle),
        .cfg_clkcfg_dis (c_cdis),
        .term_en        (term_en),
        .aligned        (aligned),
        .sob_pulse      (sob_pulse),
        .out_byte       (out_byte),
        .sync_err       (sync_err),
        .clk_active     (clk_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs, then sample outputs for that cycle
    task automatic step(input logic [1:0] l, input logic [7:0] b);
        @(negedge clk);
        lp = l;
        hb = b;
        #1;
        o_term = term_en;
        o_al   = aligned;
        o_sob  = sob_pulse;
        o_byte = out_byte;
        o_err  = sync_err;
        o_clk  = clk_active;
    endtask

    // LP-11, LP-11, LP-01, LP-00: the next step is cycle 0
    task automatic enter();
        step(2'b11, 8'h00);
        step(2'b11, 8'h00);
        step(2'b01, 8'h00);
        step(2'b00, 8'h00);
    endtask

    task automatic t_reset();
        chk("R1 term_en", term_en, 0);
        chk("R1 aligned", aligned, 0);
        chk("R1 sob", sob_pulse, 0);
        chk("R1 sync_err", sync_err, 0);
        chk("R1 clk_active", clk_active, 0);
        chk("R1 out_byte", out_byte, 0);
        // no stop seen yet: request codes do nothing
        step(2'b01, 8'h00);
        step(2'b00, 8'h00);
        step(2'b00, 8'h00);
        chk("R1 no burst without stop", o_term, 0);
    endtask

    task automatic t_entry();
        c_term = 8'd0;
        c_settle = 8'd50;
        step(2'b11, 8'h00);
        step(2'b00, 8'h00);
        for (int i = 0; i < 6; i++) begin
            step(2'b00, 8'h00);
        end
        chk("R2 skip LP-01 starts nothing", o_term, 0);
        step(2'b11, 8'h00);
        step(2'b01, 8'h00);
        step(2'b01, 8'h00);
        step(2'b01, 8'h00);
        chk("R2 held LP-01 waits", o_term, 0);
        step(2'b00, 8'h00);
        step(2'b00, 8'h00);
        chk("R2 entry after held LP-01", o_term, 1);
    endtask

    task automatic t_term();
        c_term = 8'd4;
        c_settle = 8'd10;
        enter();
        for (int i = 0; i < 9; i++) begin
            step(2'b00, 8'h00);
            chk($sformatf("R3 term_en cycle %0d", i), o_term, (i >= 4) ? 1 : 0);
        end
    endtask

    task automatic t_settle_mask();
        c_term = 8'd2;
        c_settle = 8'd5;
        c_pat = 8'hB8;
        enter();
        for (int i = 0; i < 14; i++) begin
            step(2'b00, (i == 4) ? 8'hB8 : (i == 2) ? 8'hFF : 8'h00);
            if (i == 2) chk("R8 masked byte", o_byte, 0);
            chk($sformatf("R4 early sync ignored cycle %0d", i), o_al, 0);
        end
    endtask

    task automatic t_settle_edge();
        c_term = 8'd2;
        c_settle = 8'd5;
        c_pat = 8'hB8;
        enter();
        for (int i = 0; i < 9; i++) begin
            step(2'b00, (i == 5) ? 8'hB8 : (i == 6) ? 8'h3C : (i == 7) ? 8'h11 : 8'h00);
            if (i == 6) chk("R4 no lock before window", o_al, 0);
            if (i == 7) begin
                chk("R6 aligned", o_al, 1);
                chk("R6 sob", o_sob, 1);
                chk("R6 first byte", o_byte, 8'h3C);
            end
            if (i == 8) begin
                chk("R6 sob one cycle", o_sob, 0);
                chk("R6 second byte", o_byte, 8'h11);
            end
        end
    endtask

    task automatic t_shift();
        logic [15:0] w;
        c_term = 8'd0;
        c_settle = 8'd5;
        c_pat = 8'hB8;
        enter();
        for (int i = 0; i < 13; i++) begin
            case (i)
                9:  step(2'b00, 8'hC0);
                10: step(2'b00, 8'hA5);
                11: step(2'b00, 8'h3C);
                12: step(2'b00, 8'h77);
                default: step(2'b00, 8'h00);
            endcase
            if (i == 10) chk("R5 lock waits one cycle", o_al, 0);
            if (i == 11) begin
                w = 16'h3CA5 >> 3;
                chk("R5 offset 3 aligned", o_al, 1);
                chk("R5 offset 3 byte", o_byte, w[7:0]);
            end
            if (i == 12) begin
                w = 16'h773C >> 3;
                chk("R6 offset 3 next byte", o_byte, w[7:0]);
            end
        end
    endtask

    task automatic t_priority();
        c_term = 8'd0;
        c_settle = 8'd3;
        c_pat = 8'h00;
        enter();
        for (int i = 0; i < 6; i++) begin
            step(2'b00, (i == 4) ? 8'hF0 : (i == 5) ? 8'h5A : 8'h00);
            if (i == 5) begin
                chk("R5 lowest offset lock", o_al, 1);
                chk("R5 lowest offset byte", o_byte, 8'hF0);
            end
        end
        c_pat = 8'hB8;
    endtask

    task automatic t_abort();
        step(2'b11, 8'h00);
        chk("R7 still locked in stop cycle", o_al, 1);
        step(2'b11, 8'h00);
        chk("R7 aligned cleared", o_al, 0);
        chk("R7 term cleared", o_term, 0);
        c_term = 8'd2;
        c_settle = 8'd20;
        step(2'b01, 8'h00);
        step(2'b00, 8'h00);
        step(2'b00, 8'h00);
        chk("R7 counter restarted c0", o_term, 0);
        step(2'b00, 8'h00);
        step(2'b00, 8'h00);
        chk("R7 counter restarted c2", o_term, 1);
    endtask

    task automatic t_err();
        c_term = 8'd0;
        c_settle = 8'd3;
        c_pat = 8'hB8;
        enter();
        for (int i = 0; i < 23; i++) begin
            step(2'b00, (i >= 20) ? 8'hB8 : 8'h00);
            if (i == 19) chk("R9 no error early", o_err, 0);
            if (i == 20) chk("R9 error pulse", o_err, 1);
            if (i == 21) chk("R9 error single", o_err, 0);
            if (i == 22) chk("R9 no lock after fail", o_al, 0);
        end
    endtask

    task automatic t_clk();
        c_cmode = 1'b1;
        c_cdis = 1'b0;
        c_cterm = 8'd3;
        c_csettle = 8'd4;
        c_term = 8'd9;
        c_settle = 8'd9;
        enter();
        for (int i = 0; i < 8; i++) begin
            step(2'b00, 8'hB8);
            chk($sformatf("R10 term cycle %0d", i), o_term, (i >= 3) ? 1 : 0);
            chk($sformatf("R10 clk_active cycle %0d", i), o_clk, (i >= 5) ? 1 : 0);
            if (i == 7) chk("R10 no sync search", o_al, 0);
        end
        c_cdis = 1'b1;
        enter();
        for (int i = 0; i < 17; i++) begin
            step(2'b00, 8'h00);
            if (i == 0) chk("R11 default term 0", o_term, 1);
            if (i == 14) chk("R11 not settled at 14", o_clk, 0);
            if (i == 15) chk("R11 settled at 15", o_clk, 1);
        end
        c_cmode = 1'b0;
        c_cdis = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset_pre();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_entry();
        t_term();
        t_settle_mask();
        t_settle_edge();
        t_shift();
        t_priority();
        t_abort();
        t_err();
        t_clk();
        done = 1;
        finish_run();
    end

    task automatic t_reset_pre();
        chk("R1 outputs low in reset", {term_en, aligned, sob_pulse, sync_err, clk_active}, 0);
    endtask

endmodule